// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a serial bit stream and cuts it into back-to-back frames of four accepted bits. It has one Mealy output. That output rises during the cycle that presents the last bit of a frame, and only when the whole frame equals one of two target words. Once a frame has diverged from every target, the block stops trying to match it. It still counts the remaining bits so that it can rejoin the frame boundary. Every frame boundary returns the block to its start state, so matches never overlap across frames.

A qualifying strobe marks which cycles carry a bit. Cycles without the strobe neither advance the frame nor raise the output. A synchronous active-high reset puts the block at the first position of a fresh frame. The frame length and the target words are parameters. The default is four-bit frames with the targets 0101 and 1001. Bits are listed in arrival order, so the leftmost bit arrives first.

Top module: `frame_pattern_detector`

## Requirements
- R1: After a cycle with `rst` high, the block sits at frame position 0, and the next four cycles with `in_valid` high make up one frame.
- R2: `hit_out` is 1 in the cycle that presents the fourth valid bit of a frame when the bits of that frame, in arrival order, are 0101 or 1001.
- R3: `hit_out` is 0 while the first, second or third bit of a frame is presented, and it is 0 on the fourth bit of any frame that is neither 0101 nor 1001.
- R4: A frame that opens with 00 or 11 gives no 1 on `hit_out`. The block still counts that frame's third and fourth bits, and the frame that follows starts right after the fourth bit.
- R5: On the clock edge that accepts the fourth valid bit, the block returns to frame position 0 whatever the bit values were. A match can therefore never be built from bits taken from two different frames.
- R6: In a cycle with `in_valid` low, `hit_out` is 0 and the value on `in_bit` is ignored: the frame position and the match progress keep their values.
- R7: `hit_out` is a combinational function of the present state and the present `in_bit`. Once the first three bits of a frame are 010, `hit_out` follows `in_bit` within the same cycle.
- R8: A `rst` pulse in the middle of a frame throws away the partial frame. The next valid bit is then the first bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to frame position 0 |
| in_valid | input | 1 | High when `in_bit` carries a stream bit this cycle |
| in_bit | input | 1 | Serial stream bit |
| hit_out | output | 1 | Mealy match flag for the frame ending this cycle |

## Verification
The bench builds the block with its default parameters: four-bit frames and the two target words 0101 and 1001. These two targets share a second half and differ only in the opening pair, and the remaining openings 00 and 11 fail at once. With these values the shared tail, both live openings and both dead-path openings can all be reached with short directed frames and with a few thousand random bits. Random gaps in the strobe and a reset in the middle of a frame are mixed in, so the hold and resynchronisation behaviour is exercised against a bench model that records whole frames.

// File: rtl/fd_pkg.sv
package fd_pkg;

    localparam int DEF_FRAME_BITS = 4;
    localparam int DEF_NUM_PATS   = 2;

    // per-target tracker view handed back to the top
    typedef struct packed {
        logic alive;
        logic hit;
    } trk_status_t;

    function automatic logic any_hit(input logic [31:0] hits, input int n);
        logic r;
        r = 1'b0;
        for (int i = 0; i < n; i++) r = r | hits[i];
        return r;
    endfunction

endpackage

// File: rtl/fd_frame_pos.sv
module fd_frame_pos #(
    parameter int FRAME_BITS = 4,
    localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [POS_W-1:0] pos,
    output logic             at_last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    assign at_last = (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst)          pos <= '0;
        else if (adv)     pos <= at_last ? '0 : pos + 1'b1;
    end

    // R5: the edge that takes the final bit returns to position 0
    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (pos == '0));

    // R6: without the strobe the position holds
    assert_hold_pos_R6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(pos));

    // R1: the position never leaves the frame range
    assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST_POS);

endmodule

// File: rtl/fd_pat_track.sv
module fd_pat_track #(
    parameter int FRAME_BITS = 4,
    parameter logic [FRAME_BITS-1:0] PATTERN = 4'b0101,
    localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_bit,
    input  logic [POS_W-1:0]    pos,
    input  logic                at_last,
    output fd_pkg::trk_status_t status
);

    logic [POS_W-1:0] idx;
    logic             want;
    logic             agree;
    logic             alive;

    // first arriving bit sits at the MSB of the pattern
    always_comb begin
        idx   = POS_W'(FRAME_BITS - 1) - pos;
        want  = PATTERN[idx];
        agree = (in_bit == want);
    end

    always_ff @(posedge clk) begin
        if (rst)                alive <= 1'b1;
        else if (in_valid) begin
            if (at_last)        alive <= 1'b1;
            else                alive <= alive & agree;
        end
    end

    assign status.alive = alive;
    assign status.hit   = in_valid & at_last & alive & agree;

    // R4: a rejected frame stays rejected until its final bit
    assert_dead_stays_R4: assert property (@(posedge clk) disable iff (rst)
        (!alive && !at_last) |=> !alive);

    // R5: each new frame starts with the tracker re-armed
    assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && at_last) |=> alive);

endmodule

// File: rtl/frame_pattern_detector.sv
module frame_pattern_detector #(
    parameter int FRAME_BITS = fd_pkg::DEF_FRAME_BITS,
    parameter int NUM_PATS   = fd_pkg::DEF_NUM_PATS,
    parameter logic [NUM_PATS*FRAME_BITS-1:0] PATTERNS = {4'b1001, 4'b0101},
    localparam int POS_W = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic hit_out
);

    logic [POS_W-1:0]    pos;
    logic                at_last;
    logic [31:0]         hits;
    fd_pkg::trk_status_t stat [NUM_PATS];

    fd_frame_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .pos     (pos),
        .at_last (at_last)
    );

    for (genvar g = 0; g < NUM_PATS; g++) begin : g_trk
        fd_pat_track #(
            .FRAME_BITS (FRAME_BITS),
            .PATTERN    (PATTERNS[g*FRAME_BITS +: FRAME_BITS])
        ) u_trk (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .in_bit   (in_bit),
            .pos      (pos),
            .at_last  (at_last),
            .status   (stat[g])
        );
    end

    always_comb begin
        hits = '0;
        for (int i = 0; i < NUM_PATS; i++) hits[i] = stat[i].hit;
    end

    assign hit_out = fd_pkg::any_hit(hits, NUM_PATS);

    // R3: the flag only appears on the final bit position
    assert_hit_last_R3: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> at_last);

    // R6: no flag without the strobe
    assert_hit_valid_R6: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> in_valid);

    // R2: a flag needs at least one tracker still alive
    assert_hit_alive_R2: assert property (@(posedge clk) disable iff (rst)
        hit_out |-> (stat[0].alive || stat[NUM_PATS-1].alive));

endmodule

// File: tb/sim_frame_pattern_detector.sv
module sim_frame_pattern_detector;

    logic clk = 1'b0;
    logic rst, in_valid, in_bit;
    logic hit_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 0;

    // bench model
    int       m_cnt = 0;
    logic [2:0] m_hist = '0;

    always #5 clk = ~clk;

    frame_pattern_detector u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .hit_out(hit_out)
    );

    function automatic logic expect_hit(input logic v, input logic b);
        logic [3:0] w;
        w = {m_hist, b};
        return v && (m_cnt == 3) && (w == 4'b0101 || w == 4'b1001);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: hit_out=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic model_edge(input logic r, input logic v, input logic b);
        if (r) begin
            m_cnt = 0; m_hist = '0;
        end else if (v) begin
            m_hist = {m_hist[1:0], b};
            m_cnt  = (m_cnt == 3) ? 0 : m_cnt + 1;
        end
    endtask

    // drive at falling edge, check away from the rising edge, then clock
    task automatic step(input logic v, input logic b, input string req);
        @(negedge clk);
        rst = 1'b0; in_valid = v; in_bit = b;
        #1;
        check(req, hit_out, expect_hit(v, b));
        @(posedge clk);
        model_edge(1'b0, v, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
        @(posedge clk);
        model_edge(1'b1, 1'b1, 1'b1);
    endtask

    task automatic frame(input logic [3:0] w, input string req);
        for (int i = 3; i >= 0; i--) step(1'b1, w[i], req);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0;
        do_reset();
        do_reset();

        // R1: reset state, first frame starts immediately
        frame(4'b0101, "R1");
        // R2: both targets
        frame(4'b0101, "R2");
        frame(4'b1001, "R2");
        // R3: near misses and non-targets
        frame(4'b0100, "R3");
        frame(4'b1011, "R3");
        frame(4'b0111, "R3");
        // R4: dead openings still count to four
        frame(4'b0001, "R4");
        frame(4'b1101, "R4");
        frame(4'b0101, "R4");
        // R5: pattern straddling a boundary must not hit
        frame(4'b1101, "R5");
        frame(4'b0110, "R5");
        frame(4'b1001, "R5");
        // R6: gaps with toggling bit ignored
        step(1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, "R6");
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        // R7: Mealy output follows the present input
        step(1'b1, 1'b0, "R7");
        step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, "R7");
        @(negedge clk);
        in_valid = 1'b1; in_bit = 1'b0; #1;
        check("R7", hit_out, 1'b0);
        in_bit = 1'b1; #1;
        check("R7", hit_out, 1'b1);
        in_bit = 1'b0; #1;
        check("R7", hit_out, 1'b0);
        in_bit = 1'b1; #1;
        @(posedge clk);
        model_edge(1'b0, 1'b1, 1'b1);
        // R8: reset mid-frame
        step(1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, "R8");
        do_reset();
        frame(4'b1001, "R8");
        step(1'b1, 1'b0, "R8");
        do_reset();
        frame(4'b0101, "R8");

        // random mix, checked against the frame model
        for (int n = 0; n < 3000; n++) begin
            logic v, b;
            v = ($urandom % 5) != 0;
            b = $urandom % 2;
            step(v, b, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
    end

endmodule